// File: doc/BRIEF.md
# Coarse Quarter-Rate Complex Mixer

This block moves a complex baseband stream by a fixed fraction of the sample rate. It works on one signed I/Q pair per clock. The shifts on offer are half the sample rate, plus a quarter of it and minus a quarter of it. A bypass setting passes the data through unchanged. No multipliers are used. Every rotation by a multiple of 90 degrees reduces to negating and swapping the two components.

A two-bit phase counter picks the rotation applied to each sample. A one-cycle strobe reloads the counter with a selectable starting phase. Several instances that see the same strobe therefore start their rotation sequences in step.

The block is used only when the fine mixer and the quadrature correction path are both idle. If either of them is active, the block is forced into bypass.

Top module: `coarse_iq_rotator`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, both outputs are zero. The phase counter resets to 0.
- R2: With mode 2'b00 (bypass), out_a equals in_i and out_b equals in_q from the previous clock. In this mode the phase counter does not move.
- R3: With mode 2'b01 (half rate), an even counter value gives (I, Q) and an odd value gives (−I, −Q). The counter increments by one each clock.
- R4: With mode 2'b10 (plus quarter rate), the counter increments by one each clock. Counter values 0, 1, 2 and 3 give (out_a, out_b) = (I, Q), (−Q, I), (−I, −Q) and (Q, −I).
- R5: With mode 2'b11 (minus quarter rate), the per-value mapping is the same as in R4. The counter decrements by one each clock, so the sequence runs through the same rotations in reverse.
- R6: A strobe held high for a single clock loads init_ph into the counter. The strobe takes priority over advancing, and it acts in every mode. The sample presented in the clock after the strobe is rotated by the loaded phase.
- R7: When fine_busy is high, the block behaves exactly as in bypass, whatever the mode input says. The counter holds its value.
- R8: Negating the most negative two's-complement value gives the most positive value.
- R9: Both outputs are registered. Each output reflects the inputs exactly one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_i | input | DW | In-phase sample, signed |
| in_q | input | DW | Quadrature sample, signed |
| mode | input | 2 | 00 bypass, 01 half rate, 10 plus quarter, 11 minus quarter |
| init_ph | input | 2 | Counter value loaded by the strobe |
| strobe | input | 1 | Reloads the phase counter |
| fine_busy | input | 1 | Fine mixer or correction active; forces bypass |
| out_a | output | DW | Mixed in-phase output |
| out_b | output | DW | Mixed quadrature output |

## Verification
The bench builds the block with DW set to 8. This keeps the most negative sample at −128, so the saturation case of R8 shows up in short hand-written vectors on both output lanes. A table sets each (mode, phase) pair through the strobe and checks a single rotated sample. Directed runs then let the counter free-run in each mode and compare whole rotation sequences. Further runs show that the counter holds through bypass and through a forced bypass, and that a strobe arriving mid-run lands on the next sample.

// File: rtl/coarse_iq_rotator.sv
module coarse_iq_rotator #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_i,
  input  logic [DW-1:0] in_q,
  input  logic [1:0]    mode,
  input  logic [1:0]    init_ph,
  input  logic          strobe,
  input  logic          fine_busy,
  output logic [DW-1:0] out_a,
  output logic [DW-1:0] out_b
);

  localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic [1:0] M_PASS = 2'b00;
  localparam logic [1:0] M_HALF = 2'b01;
  localparam logic [1:0] M_QPOS = 2'b10;
  localparam logic [1:0] M_QNEG = 2'b11;

  function automatic logic [DW-1:0] neg_sat(input logic [DW-1:0] x);
    return (x == MINV) ? MAXV : (~x + DW'(1));
  endfunction

  logic [1:0]    phase;
  logic [1:0]    eff_mode;
  logic [1:0]    rot;
  logic [DW-1:0] ni, nq, a_nx, b_nx;

  assign eff_mode = fine_busy ? M_PASS : mode;
  assign ni = neg_sat(in_i);
  assign nq = neg_sat(in_q);

  always_comb begin
    case (eff_mode)
      M_HALF:  rot = {phase[0], 1'b0};
      M_QPOS,
      M_QNEG:  rot = phase;
      default: rot = 2'd0;
    endcase
  end

  always_comb begin
    case (rot)
      2'd1:    begin a_nx = nq;   b_nx = in_i; end
      2'd2:    begin a_nx = ni;   b_nx = nq;   end
      2'd3:    begin a_nx = in_q; b_nx = ni;   end
      default: begin a_nx = in_i; b_nx = in_q; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 2'd0;
      out_a <= '0;
      out_b <= '0;
    end else begin
      out_a <= a_nx;
      out_b <= b_nx;
      if (strobe)
        phase <= init_ph;
      else if (eff_mode == M_HALF || eff_mode == M_QPOS)
        phase <= phase + 2'd1;
      else if (eff_mode == M_QNEG)
        phase <= phase - 2'd1;
    end
  end

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PASS || fine_busy) |=> (out_a == $past(in_i) && out_b == $past(in_q))); // R2
  AST_STROBE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (phase == $past(init_ph))); // R6
  AST_HOLD_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && fine_busy) |=> $stable(phase)); // R7
  AST_QNEG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !fine_busy && mode == M_QNEG) |=> (phase == $past(phase) - 2'd1)); // R5
  AST_QPOS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !fine_busy && mode == M_QPOS) |=> (phase == $past(phase) + 2'd1)); // R4
  AST_SAT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (!fine_busy && mode == M_HALF && phase[0] && in_i == MINV) |=> (out_a == MAXV)); // R8

endmodule

// File: tb/coarse_iq_rotator_bench.sv
`timescale 1ns/1ps
module coarse_iq_rotator_bench;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] in_i = '0, in_q = '0;
  logic [1:0] mode = 2'b00, init_ph = 2'b00;
  logic strobe = 1'b0, fine_busy = 1'b0;
  logic [DW-1:0] out_a, out_b;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  coarse_iq_rotator #(.DW(DW)) u_coarse_iq_rotator (
    .clk(clk), .rst_n(rst_n), .in_i(in_i), .in_q(in_q), .mode(mode),
    .init_ph(init_ph), .strobe(strobe), .fine_busy(fine_busy),
    .out_a(out_a), .out_b(out_b));

  typedef struct packed {
    logic [1:0] m; logic [1:0] p;
    logic [7:0] i; logic [7:0] q; logic [7:0] ea; logic [7:0] eb;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{2'd0, 2'd3, 8'h05, 8'hF9, 8'h05, 8'hF9},  // R2
    '{2'd1, 2'd0, 8'h0A, 8'h14, 8'h0A, 8'h14},  // R3
    '{2'd1, 2'd1, 8'h0A, 8'h14, 8'hF6, 8'hEC},  // R3
    '{2'd2, 2'd1, 8'h03, 8'h09, 8'hF7, 8'h03},  // R4
    '{2'd2, 2'd2, 8'h03, 8'h09, 8'hFD, 8'hF7},  // R4
    '{2'd2, 2'd3, 8'h03, 8'h09, 8'h09, 8'hFD},  // R4
    '{2'd3, 2'd1, 8'h03, 8'h09, 8'hF7, 8'h03},  // R5
    '{2'd3, 2'd3, 8'h80, 8'h04, 8'h04, 8'h7F},  // R8
    '{2'd1, 2'd1, 8'h80, 8'h80, 8'h7F, 8'h7F},  // R8
    '{2'd2, 2'd1, 8'h00, 8'h80, 8'h7F, 8'h00}   // R8
  };

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] ea, input logic [7:0] eb);
    checks++;
    if (out_a !== ea || out_b !== eb) begin
      errors++;
      $display("FAIL %s: got a=%h b=%h expected a=%h b=%h", tag, out_a, out_b, ea, eb);
    end
  endtask

  task automatic load(input logic [1:0] m, input logic [1:0] p);
    mode = m; init_ph = p; strobe = 1'b1;
    step();
    strobe = 1'b0;
  endtask

  task automatic feed(input logic [7:0] i, input logic [7:0] q);
    in_i = i; in_q = q;
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    in_i = 8'h55; in_q = 8'h33;
    @(negedge clk); @(negedge clk);
    check("R1 in reset", 8'h00, 8'h00);
    rst_n = 1'b1;
    check("R1 after release", 8'h00, 8'h00);

    foreach (TBL[k]) begin
      load(TBL[k].m, TBL[k].p);
      feed(TBL[k].i, TBL[k].q);
      check($sformatf("table %0d", k), TBL[k].ea, TBL[k].eb);
    end

    // R4 free run from phase 0
    load(2'd2, 2'd0);
    feed(8'h03, 8'h09); check("R4 p0", 8'h03, 8'h09);
    feed(8'h03, 8'h09); check("R4 p1", 8'hF7, 8'h03);
    feed(8'h03, 8'h09); check("R4 p2", 8'hFD, 8'hF7);
    feed(8'h03, 8'h09); check("R4 p3", 8'h09, 8'hFD);
    feed(8'h03, 8'h09); check("R4 wrap", 8'h03, 8'h09);

    // R5 free run from phase 0
    load(2'd3, 2'd0);
    feed(8'h03, 8'h09); check("R5 p0", 8'h03, 8'h09);
    feed(8'h03, 8'h09); check("R5 p3", 8'h09, 8'hFD);
    feed(8'h03, 8'h09); check("R5 p2", 8'hFD, 8'hF7);
    feed(8'h03, 8'h09); check("R5 p1", 8'hF7, 8'h03);

    // R3 free run from phase 2
    load(2'd1, 2'd2);
    feed(8'h0A, 8'h14); check("R3 p2", 8'h0A, 8'h14);
    feed(8'h0A, 8'h14); check("R3 p3", 8'hF6, 8'hEC);
    feed(8'h0A, 8'h14); check("R3 p0", 8'h0A, 8'h14);

    // R2 and R9: pass-through one clock late, counter held
    load(2'd2, 2'd1);
    mode = 2'd0;
    feed(8'h11, 8'h22); check("R2 R9 pass 1", 8'h11, 8'h22);
    feed(8'h80, 8'h7F); check("R2 R9 pass 2", 8'h80, 8'h7F);
    feed(8'h01, 8'hFF); check("R2 R9 pass 3", 8'h01, 8'hFF);
    mode = 2'd2;
    feed(8'h03, 8'h09); check("R2 counter held", 8'hF7, 8'h03);

    // R7: forced bypass
    load(2'd2, 2'd1);
    fine_busy = 1'b1;
    feed(8'h03, 8'h09); check("R7 forced pass 1", 8'h03, 8'h09);
    mode = 2'd3;
    feed(8'h44, 8'hC0); check("R7 forced pass 2", 8'h44, 8'hC0);
    fine_busy = 1'b0; mode = 2'd2;
    feed(8'h03, 8'h09); check("R7 counter held", 8'hF7, 8'h03);

    // R6: a mid-run strobe lands on the next sample
    load(2'd2, 2'd0);
    feed(8'h03, 8'h09); check("R6 before", 8'h03, 8'h09);
    in_i = 8'h03; in_q = 8'h09; init_ph = 2'd3; strobe = 1'b1;
    step(); strobe = 1'b0;
    check("R6 strobe cycle uses old phase", 8'hF7, 8'h03);
    feed(8'h03, 8'h09); check("R6 loaded phase", 8'h09, 8'hFD);

    finish_run();
  end
endmodule